// File: doc/BRIEF.md
# Supply-Aware Write Guard for a Battery-Backed Byte Store

This block sits between a host's chip-select / write / output-enable strobes and a small battery-backed byte store. It protects stored data while the main supply is unhealthy. A digital power-good input reports whether the supply is in tolerance, and a digital battery-ok input reports the state of the backup cell. Analog sensing is done elsewhere.

The guard blocks every write while power-good is low. After power returns, it ignores all accesses for a parameterised number of clock cycles. It also samples the battery on every power-good rise and latches a weak-battery flag. It does not report that flag through a register. Instead, it silently discards exactly one write: the first write strobe that starts once the store is accessible. The flag then clears by itself. Software detects a weak cell with three steps: read a byte, write back its complement, and read it again. If the byte is unchanged, the battery is weak.

Top module: `pwrguard_top`

## Requirements
- R1: While `pwr_good` is low, no write strobe changes the store, `rdata_vld` stays 0 and `rdata` stays 0.
- R2: On each clock edge where `pwr_good` is first seen high, the guard copies the inverse of `batt_ok` into its weak-battery flag.
- R3: With the flag set, the first write strobe that begins while the store is accessible is discarded, and the stored byte keeps its old value.
- R4: That discarded strobe clears the flag, and the next write strobe stores its data normally.
- R5: If `batt_ok` was high at the power-good rise, the very first write after recovery is stored.
- R6: The recovery window after a power-good rise works as follows.
  - A read held from the rise gets `rdata_vld`=1 first after clock edge RECOVER_CYC+2, counting the rise edge as edge 1.
  - A write strobe that begins inside the window is discarded.
  - Such a strobe does not clear the weak-battery flag.
- R7: A read is requested when `ce_n`=0, `oe_n`=0 and `we_n`=1.
  - After the next clock edge, `rdata_vld`=1 and `rdata` holds the byte stored at `addr`.
  - When no valid read took place, `rdata` is 0.
- R8: A write strobe lasts while `ce_n` and `we_n` are both low, whichever of them falls last. It ends when either one rises. The byte stored is the `wdata` present in the last cycle of the strobe, at the `addr` present in that cycle.
- R9: If `pwr_good` falls while a write strobe is active, that write is abandoned and the store is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply in tolerance |
| batt_ok | input | 1 | Backup cell healthy; sampled on the power-good rise |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when not valid |
| rdata_vld | output | 1 | Read data valid |

## Verification
The bench builds the guard with ADDR_W=4 and RECOVER_CYC=5. The sixteen-byte store makes random traffic revisit every address many times. The short recovery window puts the exact first-valid edge, and writes placed inside the window, within a few cycles. Several power cycles are driven with the battery good and weak. This covers the discarded-first-write path, the complement-write detection sequence, and a write abandoned when the supply drops mid-strobe.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    // Phase of a host write strobe as seen by the guard
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no strobe in progress
        PH_PASS = 2'd1,   // strobe accepted, commit at its end
        PH_DROP = 2'd2    // strobe discarded, wait for its end
    } wr_phase_e;
endpackage

// File: rtl/pgw_supply.sv
module pgw_supply #(
    parameter int RECOVER_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic batt_ok,
    input  logic consume,
    output logic ready,
    output logic batt_low
);
    localparam int CW = (RECOVER_CYC < 1) ? 1 : $clog2(RECOVER_CYC + 1);

    typedef struct packed {
        logic          pg;
        logic [CW-1:0] cnt;
        logic          low;
    } sup_t;

    sup_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.pg = pwr_good;
        if (!pwr_good) begin
            s_d.cnt = '0;
        end else if (!s_q.pg) begin
            s_d.cnt = CW'(RECOVER_CYC);
            s_d.low = ~batt_ok;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (consume) begin
            s_d.low = 1'b0;
        end
        ready    = pwr_good & s_q.pg & (s_q.cnt == '0);
        batt_low = s_q.low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_FLAG_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.low) |-> $past(pwr_good & !s_q.pg)); // R2

    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !batt_low); // R4
endmodule

// File: rtl/pgw_strobe.sv
module pgw_strobe
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    input  logic              batt_low,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              consume
);
    typedef struct packed {
        wr_phase_e         ph;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } stb_t;

    stb_t s_d, s_q;
    logic act;

    always_comb begin
        act     = ~ce_n & ~we_n;
        s_d     = s_q;
        commit  = 1'b0;
        consume = 1'b0;
        if (act) begin
            s_d.a = addr;
            s_d.d = wdata;
        end
        unique case (s_q.ph)
            PH_IDLE: begin
                if (act) begin
                    consume = ready & batt_low;
                    s_d.ph  = (ready && !batt_low) ? PH_PASS : PH_DROP;
                end
            end
            PH_PASS: begin
                if (!act) begin
                    commit = ready;
                    s_d.ph = PH_IDLE;
                end else if (!ready) begin
                    s_d.ph = PH_DROP;
                end
            end
            default: begin
                if (!act) begin
                    s_d.ph = PH_IDLE;
                end
            end
        endcase
        commit_addr = s_q.a;
        commit_data = s_q.d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, a: '0, d: '0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_COMMIT_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (s_q.ph == PH_IDLE)); // R8

    AST_CONSUME_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (s_q.ph == PH_DROP)); // R3
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_t r_d, r_q;

    always_comb begin
        r_d.vld  = rd_en;
        r_d.data = rd_en ? mem_q[rd_addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Battery-backed contents: never cleared by reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rdata     = r_q.data;
    assign rdata_vld = r_q.vld;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rdata_vld); // R7
endmodule

// File: rtl/pwrguard_top.sv
module pwrguard_top #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int RECOVER_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              batt_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    logic              ready;
    logic              batt_low;
    logic              consume;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic              rd_en;

    assign rd_en = ready & ~ce_n & ~oe_n & we_n;

    pgw_supply #(.RECOVER_CYC(RECOVER_CYC)) u_supply (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .batt_ok  (batt_ok),
        .consume  (consume),
        .ready    (ready),
        .batt_low (batt_low)
    );

    pgw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .we_n        (we_n),
        .addr        (addr),
        .wdata       (wdata),
        .ready       (ready),
        .batt_low    (batt_low),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .consume     (consume)
    );

    pgw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .wr_addr   (commit_addr),
        .wr_data   (commit_data),
        .rd_en     (rd_en),
        .rd_addr   (addr),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    AST_NO_WRITE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> pwr_good); // R1

    AST_NO_READ_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !rdata_vld); // R1

    AST_NO_COMMIT_WHILE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !batt_low); // R3

    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> $past(ready)); // R6

    AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == '0)); // R7
endmodule

// File: tb/pwrguard_top_bench.sv
module pwrguard_top_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int REC   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b0;
    logic          batt_ok = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_vld;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] exp_mem [1 << AW];
    bit            exp_low = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    pwrguard_top #(.ADDR_W(AW), .DATA_W(DW), .RECOVER_CYC(REC)) u_pwrguard_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .batt_ok   (batt_ok),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    function automatic logic [DW-1:0] inv_byte(input logic [DW-1:0] v);
        return ~v;
    endfunction

    // Whether a read is expected valid k edges after the power-good rise
    function automatic bit vld_after(input int k);
        return k >= REC + 2;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // Raise power with a read held; checks the first valid edge (R6)
    task automatic power_up(input bit bok);
        pwr_good = 1'b1; batt_ok = bok;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = '0;
        for (int k = 1; k <= REC + 3; k++) begin
            tick();
            chk(rdata_vld == vld_after(k), "R6 recovery window", rdata_vld, vld_after(k));
        end
        idle();
        tick();
        exp_low = !bok; // R2
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        tick();
        idle();
        tick();
        if (exp_low) exp_low = 1'b0;
        else exp_mem[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req, output logic [DW-1:0] got);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        tick();
        chk(rdata_vld == 1'b1, req, rdata_vld, 1);
        chk(rdata == exp_mem[a], req, rdata, exp_mem[a]);
        got = rdata;
        idle();
        tick();
        chk(rdata == '0, "R7 zero when idle", rdata, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] got;
        int unused_seed;
        unused_seed = $urandom(32'd11);

        // Reset state
        repeat (3) tick();
        chk(rdata_vld == 1'b0, "R7 reset valid", rdata_vld, 0);
        chk(rdata == '0, "R7 reset data", rdata, 0);
        rst_n = 1'b1;
        tick();

        // Good battery: first write stored (R5)
        power_up(1'b1);
        do_write(4'd3, 8'hA5);
        do_read(4'd3, "R5 first write stored", got);
        for (int i = 0; i < (1 << AW); i++) begin
            do_write(AW'(i), DW'($urandom));
        end

        // Random traffic (R7, R8)
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            if ($urandom % 2) do_write(ra, DW'($urandom));
            else do_read(ra, "R7 random read", got);
        end

        // R8: address/data of last strobe cycle win
        ce_n = 1'b0; we_n = 1'b0; addr = 4'd1; wdata = 8'h11;
        tick();
        addr = 4'd2; wdata = 8'h22;
        tick();
        idle();
        tick();
        exp_mem[2] = 8'h22;
        do_read(4'd1, "R8 earlier address untouched", got);
        do_read(4'd2, "R8 last cycle data", got);
        // R8: write strobe low first, select falls later, select rises first
        we_n = 1'b0; ce_n = 1'b1; addr = 4'd5; wdata = 8'h5C;
        tick();
        ce_n = 1'b0;
        tick();
        ce_n = 1'b1;
        tick();
        we_n = 1'b1;
        tick();
        exp_mem[5] = 8'h5C;
        do_read(4'd5, "R8 select-timed write", got);

        // R1: power down, writes and reads blocked
        pwr_good = 1'b0;
        tick();
        ce_n = 1'b0; we_n = 1'b0; addr = 4'd5; wdata = 8'hEE;
        tick();
        idle();
        tick();
        ce_n = 1'b0; oe_n = 1'b0; addr = 4'd5;
        tick();
        chk(rdata_vld == 1'b0, "R1 read blocked", rdata_vld, 0);
        chk(rdata == '0, "R1 data zero", rdata, 0);
        idle();
        tick();

        // R2/R3/R4: weak battery, complement-write check sequence
        power_up(1'b0);
        do_read(4'd7, "R3 initial read", v);
        do_write(4'd7, inv_byte(v));
        do_read(4'd7, "R3 first write discarded", got);
        chk(got == v, "R3 value unchanged detects weak cell", got, v);
        do_read(4'd5, "R1 no write while unpowered", got);
        do_write(4'd7, inv_byte(v));
        do_read(4'd7, "R4 later write stored", got);
        chk(got == inv_byte(v), "R4 complement now present", got, inv_byte(v));

        // R6: write inside recovery is discarded and keeps the flag
        pwr_good = 1'b0;
        tick();
        pwr_good = 1'b1; batt_ok = 1'b0;
        ce_n = 1'b0; we_n = 1'b0; addr = 4'd9; wdata = inv_byte(exp_mem[9]);
        tick();
        tick();
        idle();
        repeat (REC + 3) tick();
        exp_low = 1'b1;
        do_read(4'd9, "R6 recovery write discarded", got);
        do_write(4'd9, 8'h3C); // consumed by the flag
        do_read(4'd9, "R6 flag survived recovery write", got);
        do_write(4'd9, 8'h3C);
        do_read(4'd9, "R4 write after consume", got);

        // R9: power lost mid-strobe
        ce_n = 1'b0; we_n = 1'b0; addr = 4'd9; wdata = 8'hC3;
        tick();
        pwr_good = 1'b0;
        tick();
        idle();
        tick();
        power_up(1'b1);
        do_read(4'd9, "R9 abandoned write", got);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule